// File: doc/BRIEF.md
# Scattered-Slot 64-Source Interrupt Controller

This block collects up to 64 active-low interrupt lines into two 32-bit banks, called high and low. Each bank has an enable (mask) register and a pending register. Software programs the masks, clears pending bits by writing ones, and reads a vector word. The vector word names the most urgent pending, enabled source, and a single request output tells the processor that at least one such source exists.

Source numbers do not map to bank bits in any arithmetic way. A fixed placement table decides which bank and which bit each source occupies. The way a line is sensed depends on its class:

- Most sources are plain internal lines and are always level-low.
- A small group of external lines can be set to level-low or to falling-edge.
- A group of port lines can be set to both-edge or to falling-edge.

A single sense register holds the selection bits for the external and port lines.

Software reaches the block through a plain synchronous register port. It has one address and one data bus, with a write strobe and a read strobe. There is no back-pressure: a write always takes effect at the clock edge where the strobe is sampled, and a read always returns its data one cycle after the strobe. Source lines are treated as synchronous to `clk`.

Top module: `sirq_ctrl`

## Requirements
- R1: The placement of sources into bank and bit is fixed:
  - Source 0 is high bit 0, which is reserved, see R3.
  - Sources 1..15 are high bits 15..1, in that order.
  - Sources 16, 17 and 18 are low bits 2, 1 and 0.
  - Sources 19..30 are low bits 14..3.
  - Sources 32..47 are high bits 31..16.
  - Sources 48..63 are low bits 16..31.
- R2: A mask bit of 1 enables its source and a mask bit of 0 blocks it. `irq` is 1 exactly when some source is both pending and enabled.
- R3: Sources 0 and 31 are reserved and never become pending or qualify. High bit 0 and low bit 15 of the mask and pending registers always read 0.
- R4: Writing a pending register clears every bit written as 1 and leaves every bit written as 0 unchanged. If a source sets a bit in the same cycle that the bit is cleared, the set wins.
- R5: The vector register holds the number of the qualifying source in bits [31:26], with all lower bits 0. When several sources qualify, the lowest source number is reported. The value is 0 when no source qualifies.
- R6: A level-low source sets its pending bit at every clock edge where its line is 0. The bit stays set after the line returns to 1, until software clears it.
- R7: External sources 19..25 use sense bit (33 − source), which covers bits 14..8. When that bit is 1 the source pends only on a 1→0 transition of its line. When the bit is 0 the source is level-low.
- R8: Port sources 48..63 use sense bit (source − 32), which covers bits 16..31. When that bit is 1 the source pends only on a 1→0 transition. When the bit is 0 it pends on any transition of its line.
- R9: Sense bits outside 8..14 and 16..31 cannot be written and read 0. All other sources stay level-low whatever is written to the sense register.
- R10: After reset both mask registers, both pending registers, the sense register and the read data are 0, and `irq` is 0. Edge detection treats every line as previously 1.
- R11: The word addresses are:

  | Address | Register     |
  |---------|--------------|
  | 0       | mask high    |
  | 1       | mask low     |
  | 2       | pending high |
  | 3       | pending low  |
  | 4       | sense        |
  | 5       | vector       |

  Read data appears on `reg_rdata` one cycle after `reg_rd`. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_n | input | 64 | Interrupt lines, active low, indexed by source number |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The bench pulses single sources across every placement range and the two reserved slots. A design with a slip in the placement table would light the wrong pending bit, or light a bit for a reserved source. It also clears a level source while its line is still low, where a design that lets the clear win would drop the bit. It then clears edge-mode external and port sources while their lines are held, and releases port lines, to expose edge detection that re-fires on level or misses the rising edge in both-edge mode. Finally it enables overlapping sets of sources to catch a priority encoder that picks the highest number or leaks a vector when nothing is enabled.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  localparam int NUM_SRC = 64;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 3;
  localparam int SRC_W   = $clog2(NUM_SRC);
  localparam int VEC_LSB = REG_W - SRC_W;

  typedef enum logic [ADDR_W-1:0] {
    A_MASK_HI = 3'd0,
    A_MASK_LO = 3'd1,
    A_PEND_HI = 3'd2,
    A_PEND_LO = 3'd3,
    A_SENSE   = 3'd4,
    A_VECTOR  = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    SC_LEVEL = 2'd0,
    SC_EXT   = 2'd1,
    SC_PORT  = 2'd2,
    SC_NONE  = 2'd3
  } sense_class_e;

  // Class of a source: reserved, always-level, selectable external, or port.
  function automatic sense_class_e src_class(int s);
    if (s == 0 || s == 31)       return SC_NONE;
    else if (s >= 19 && s <= 25) return SC_EXT;
    else if (s >= 48)            return SC_PORT;
    else                         return SC_LEVEL;
  endfunction

  // Bank holding a source: 1 = high bank, 0 = low bank.
  function automatic logic src_in_high(int s);
    return (s < 16) || (s >= 32 && s < 48);
  endfunction

  // Bit position of a source inside its bank.
  function automatic int src_bit(int s);
    if (s == 0)       return 0;
    else if (s < 16)  return 16 - s;
    else if (s < 19)  return 18 - s;
    else if (s < 31)  return 33 - s;
    else if (s == 31) return 15;
    else if (s < 48)  return 63 - s;
    else              return s - 32;
  endfunction

  // Edge-select bit in the sense register (only meaningful for EXT/PORT).
  function automatic int sense_bit(int s);
    if (src_class(s) == SC_EXT)       return 33 - s;
    else if (src_class(s) == SC_PORT) return s - 32;
    else                              return 0;
  endfunction

  // Bits of one bank that belong to a real source.
  function automatic logic [REG_W-1:0] bank_valid(logic high);
    logic [REG_W-1:0] v;
    v = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (src_class(s) != SC_NONE && src_in_high(s) == high) v[src_bit(s)] = 1'b1;
    end
    return v;
  endfunction

  // Writable bits of the sense register.
  function automatic logic [REG_W-1:0] sense_valid();
    logic [REG_W-1:0] v;
    v = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (src_class(s) == SC_EXT || src_class(s) == SC_PORT) v[sense_bit(s)] = 1'b1;
    end
    return v;
  endfunction

endpackage

// File: rtl/sirq_sense.sv
module sirq_sense
  import sirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_n,
  input  logic [REG_W-1:0]   sense_q,
  output logic [NUM_SRC-1:0] hit
);

  logic [NUM_SRC-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= src_n;
  end

  // Reserved sense bits and the history of level-only lines feed nothing.
  logic unused_inputs;
  assign unused_inputs = ^{sense_q & ~sense_valid(), prev_q};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam sense_class_e CLS = src_class(s);
    localparam int SB = sense_bit(s);
    if (CLS == SC_EXT) begin : g_ext
      assign hit[s] = sense_q[SB] ? (prev_q[s] & ~src_n[s]) : ~src_n[s];
    end else if (CLS == SC_PORT) begin : g_port
      assign hit[s] = sense_q[SB] ? (prev_q[s] & ~src_n[s]) : (prev_q[s] ^ src_n[s]);
    end else if (CLS == SC_LEVEL) begin : g_lvl
      assign hit[s] = ~src_n[s];
    end else begin : g_none
      assign hit[s] = 1'b0;
    end
  end

endmodule

// File: rtl/sirq_bank.sv
module sirq_bank
  import sirq_pkg::*;
#(
  parameter bit HIGH = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_we,
  input  logic             pend_we,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] set_bits,
  output logic [REG_W-1:0] mask_q,
  output logic [REG_W-1:0] pend_q
);

  localparam logic [REG_W-1:0] VALID = bank_valid(HIGH);

  logic [REG_W-1:0] clr_bits;
  assign clr_bits = pend_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      if (mask_we) mask_q <= wdata & VALID;
      pend_q <= ((pend_q & ~clr_bits) | set_bits) & VALID;
    end
  end

endmodule

// File: rtl/sirq_prio.sv
module sirq_prio
  import sirq_pkg::*;
(
  input  logic [NUM_SRC-1:0] qual,
  output logic               any,
  output logic [SRC_W-1:0]   idx
);

  logic unused_q0;
  assign unused_q0 = qual[0];

  always_comb begin
    idx = '0;
    for (int s = NUM_SRC - 1; s >= 1; s--) begin
      if (qual[s]) idx = SRC_W'(s);
    end
  end

  assign any = |qual[NUM_SRC-1:1];

endmodule

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
  import sirq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SRC-1:0]    src_n,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic                  reg_wr,
  input  logic [REG_W-1:0]      reg_wdata,
  input  logic                  reg_rd,
  output logic [REG_W-1:0]      reg_rdata,
  output logic                  irq
);

  localparam logic [REG_W-1:0] SENSE_OK = sense_valid();

  logic [REG_W-1:0]   sense_q;
  logic [NUM_SRC-1:0] hit;
  logic [REG_W-1:0]   set_hi, set_lo;
  logic [REG_W-1:0]   mask_hi_q, mask_lo_q, pend_hi_q, pend_lo_q;
  logic [NUM_SRC-1:0] qual;
  logic               any_q;
  logic [SRC_W-1:0]   win_idx;
  logic [REG_W-1:0]   vec_word;

  // Sense register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            sense_q <= '0;
    else if (reg_wr && reg_addr == A_SENSE) sense_q <= reg_wdata & SENSE_OK;
  end

  sirq_sense u_sense (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_n   (src_n),
    .sense_q (sense_q),
    .hit     (hit)
  );

  // Scatter per-source set requests into the two banks.
  always_comb begin
    set_hi = '0;
    set_lo = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (src_class(s) != SC_NONE) begin
        if (src_in_high(s)) set_hi[src_bit(s)] = hit[s];
        else                set_lo[src_bit(s)] = hit[s];
      end
    end
  end

  sirq_bank #(.HIGH(1'b1)) u_bank_hi (
    .clk      (clk),
    .rst_n    (rst_n),
    .mask_we  (reg_wr && reg_addr == A_MASK_HI),
    .pend_we  (reg_wr && reg_addr == A_PEND_HI),
    .wdata    (reg_wdata),
    .set_bits (set_hi),
    .mask_q   (mask_hi_q),
    .pend_q   (pend_hi_q)
  );

  sirq_bank #(.HIGH(1'b0)) u_bank_lo (
    .clk      (clk),
    .rst_n    (rst_n),
    .mask_we  (reg_wr && reg_addr == A_MASK_LO),
    .pend_we  (reg_wr && reg_addr == A_PEND_LO),
    .wdata    (reg_wdata),
    .set_bits (set_lo),
    .mask_q   (mask_lo_q),
    .pend_q   (pend_lo_q)
  );

  // Gather qualifying sources back into source-number order.
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_qual
    localparam int B = src_bit(s);
    if (src_class(s) == SC_NONE) begin : g_rsv
      assign qual[s] = 1'b0;
    end else if (src_in_high(s)) begin : g_hi
      assign qual[s] = mask_hi_q[B] & pend_hi_q[B];
    end else begin : g_lo
      assign qual[s] = mask_lo_q[B] & pend_lo_q[B];
    end
  end

  sirq_prio u_prio (
    .qual (qual),
    .any  (any_q),
    .idx  (win_idx)
  );

  assign irq      = any_q;
  assign vec_word = any_q ? {win_idx, {VEC_LSB{1'b0}}} : '0;

  // Registered read port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_MASK_HI: reg_rdata <= mask_hi_q;
        A_MASK_LO: reg_rdata <= mask_lo_q;
        A_PEND_HI: reg_rdata <= pend_hi_q;
        A_PEND_LO: reg_rdata <= pend_lo_q;
        A_SENSE:   reg_rdata <= sense_q;
        A_VECTOR:  reg_rdata <= vec_word;
        default:   reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/sirq_ctrl_chk.sv
module sirq_ctrl_chk
  import sirq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              reg_rd,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              irq,
  input logic [REG_W-1:0]  mask_hi,
  input logic [REG_W-1:0]  mask_lo,
  input logic [REG_W-1:0]  pend_hi,
  input logic [REG_W-1:0]  pend_lo,
  input logic [REG_W-1:0]  set_hi,
  input logic [REG_W-1:0]  sense
);

  a_r10_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask_hi == '0 && mask_lo == '0 && pend_hi == '0 &&
                      pend_lo == '0 && sense == '0 && !irq));

  a_r2_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_hi == '0 && mask_lo == '0) |-> !irq);

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_hi[0] == 1'b0 && pend_lo[15] == 1'b0 && mask_hi[0] == 1'b0 && mask_lo[15] == 1'b0));

  a_r4_clear_all_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_PEND_HI && reg_wdata == '1 && set_hi == '0) |=> (pend_hi == '0));

  a_r4_sticky_hi: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_PEND_HI) |=> ((pend_hi & $past(pend_hi)) == $past(pend_hi)));

  a_r5_idle_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_VECTOR && !irq) |=> (reg_rdata == '0));

endmodule

bind sirq_ctrl sirq_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rd    (reg_rd),
  .reg_rdata (reg_rdata),
  .irq       (irq),
  .mask_hi   (mask_hi_q),
  .mask_lo   (mask_lo_q),
  .pend_hi   (pend_hi_q),
  .pend_lo   (pend_lo_q),
  .set_hi    (set_hi),
  .sense     (sense_q)
);

// File: tb/sim_sirq_ctrl.sv
`timescale 1ns/1ps
module sim_sirq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_n = '1;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sirq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_n(src_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  // Expected placement, written from the R1 ranges.
  function automatic bit exp_hi(int s);
    return (s <= 15) || (s >= 32 && s <= 47);
  endfunction

  function automatic int exp_pos(int s);
    case (1'b1)
      (s >= 1  && s <= 15): return 16 - s;
      (s >= 16 && s <= 18): return 18 - s;
      (s >= 19 && s <= 30): return 33 - s;
      (s >= 32 && s <= 47): return 63 - s;
      (s >= 48):            return s - 32;
      default:              return 0;
    endcase
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    chk("R10 irq after reset", {31'b0, irq}, 32'h0);
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], d);
      chk($sformatf("R10 reg %0d after reset", a), d, 32'h0);
    end
  endtask

  task automatic t_map();
    int list [18] = '{0, 1, 7, 15, 16, 17, 18, 19, 25, 26, 30, 31, 32, 40, 47, 48, 55, 63};
    logic [31:0] h, l, eh, el;
    foreach (list[i]) begin
      automatic int s = list[i];
      src_n[s] = 1'b0;
      cyc(1);
      src_n[s] = 1'b1;
      cyc(2);
      rd(3'd2, h);
      rd(3'd3, l);
      eh = '0; el = '0;
      if (s != 0 && s != 31) begin
        if (exp_hi(s)) eh[exp_pos(s)] = 1'b1;
        else           el[exp_pos(s)] = 1'b1;
      end
      chk($sformatf("R1 R3 src %0d pend high", s), h, eh);
      chk($sformatf("R1 R3 src %0d pend low", s), l, el);
      wr(3'd2, '1);
      wr(3'd3, '1);
    end
  endtask

  task automatic t_mask_vec();
    logic [31:0] d;
    src_n[5] = 0; src_n[20] = 0; src_n[40] = 0; src_n[48] = 0; src_n[63] = 0;
    cyc(1);
    src_n[5] = 1; src_n[20] = 1; src_n[40] = 1; src_n[48] = 1; src_n[63] = 1;
    cyc(2);
    chk("R2 irq with all masked", {31'b0, irq}, 32'h0);
    rd(3'd5, d); chk("R5 vector all masked", d, 32'h0);
    wr(3'd0, 32'h0080_0000);
    chk("R2 irq src 40 enabled", {31'b0, irq}, 32'h1);
    rd(3'd5, d); chk("R5 vector src 40", d, 32'd40 << 26);
    wr(3'd1, 32'h8001_2000);
    rd(3'd1, d); chk("R2 mask low readback", d, 32'h8001_2000);
    rd(3'd5, d); chk("R5 vector lowest is 20", d, 32'd20 << 26);
    wr(3'd0, 32'h0080_0800);
    rd(3'd5, d); chk("R5 vector lowest is 5", d, 32'd5 << 26);
    wr(3'd2, 32'h0000_0800);
    rd(3'd5, d); chk("R4 clear src 5 then vector 20", d, 32'd20 << 26);
    wr(3'd3, 32'h0000_2000);
    rd(3'd5, d); chk("R4 clear src 20 then vector 40", d, 32'd40 << 26);
    wr(3'd3, 32'h0);
    rd(3'd3, d); chk("R4 zero write leaves low pending", d, 32'h8001_0000);
    wr(3'd2, '1);
    rd(3'd5, d); chk("R5 vector 48 after high cleared", d, 32'd48 << 26);
    wr(3'd3, '1);
    chk("R2 irq drops when nothing pending", {31'b0, irq}, 32'h0);
    rd(3'd5, d); chk("R5 vector idle", d, 32'h0);
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    src_n[3] = 1'b0;
    cyc(1);
    wr(3'd2, 32'h0000_2000);
    rd(3'd2, d); chk("R4 R6 set wins over clear while line low", d, 32'h0000_2000);
    src_n[3] = 1'b1;
    cyc(1);
    wr(3'd2, 32'h0000_2000);
    rd(3'd2, d); chk("R6 clear after release", d, 32'h0);
    src_n[10] = 1'b0; cyc(1); src_n[10] = 1'b1; cyc(4);
    rd(3'd2, d); chk("R6 level pend sticky after release", d, 32'h0000_0040);
    wr(3'd2, '1);
  endtask

  task automatic t_ext();
    logic [31:0] d;
    wr(3'd4, 32'h0000_0800);
    rd(3'd4, d); chk("R7 sense readback", d, 32'h0000_0800);
    src_n[22] = 1'b0; cyc(3);
    rd(3'd3, d); chk("R7 falling edge pends src 22", d, 32'h0000_0800);
    wr(3'd3, 32'h0000_0800); cyc(2);
    rd(3'd3, d); chk("R7 held low no re-pend in edge mode", d, 32'h0);
    src_n[22] = 1'b1; cyc(2);
    rd(3'd3, d); chk("R7 rising ignored", d, 32'h0);
    wr(3'd4, 32'h0);
    src_n[22] = 1'b0; cyc(1);
    wr(3'd3, 32'h0000_0800);
    rd(3'd3, d); chk("R7 level mode re-pends", d, 32'h0000_0800);
    src_n[22] = 1'b1; cyc(1);
    wr(3'd3, '1);
  endtask

  task automatic t_port();
    logic [31:0] d;
    src_n[50] = 1'b0; cyc(1);
    rd(3'd3, d); chk("R8 both-edge fall pends src 50", d, 32'h0004_0000);
    wr(3'd3, 32'h0004_0000);
    rd(3'd3, d); chk("R8 held low no re-pend", d, 32'h0);
    src_n[50] = 1'b1; cyc(1);
    rd(3'd3, d); chk("R8 both-edge rise pends", d, 32'h0004_0000);
    wr(3'd3, '1);
    wr(3'd4, 32'h0004_0000);
    src_n[50] = 1'b0; cyc(1);
    rd(3'd3, d); chk("R8 falling-only fall pends", d, 32'h0004_0000);
    wr(3'd3, '1);
    src_n[50] = 1'b1; cyc(1);
    rd(3'd3, d); chk("R8 falling-only rise ignored", d, 32'h0);
    wr(3'd4, 32'h0);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    wr(3'd4, '1);
    rd(3'd4, d); chk("R9 sense writable bits", d, 32'hFFFF_7F00);
    src_n[26] = 1'b0; cyc(1);
    wr(3'd3, 32'h0000_0080);
    rd(3'd3, d); chk("R9 internal src stays level", d, 32'h0000_0080);
    src_n[26] = 1'b1; cyc(1);
    wr(3'd3, '1);
    wr(3'd4, 32'h0);
    wr(3'd0, '1);
    rd(3'd0, d); chk("R3 mask high reserved bit", d, 32'hFFFF_FFFE);
    wr(3'd1, '1);
    rd(3'd1, d); chk("R3 mask low reserved bit", d, 32'hFFFF_7FFF);
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h0);
    rd(3'd6, d); chk("R11 address 6 reads 0", d, 32'h0);
    rd(3'd7, d); chk("R11 address 7 reads 0", d, 32'h0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_map();
    t_mask_vec();
    t_level();
    t_ext();
    t_port();
    t_reserved();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule